// File: doc/BRIEF.md
# Segmented Fetch Address Generator

This block produces the 32-bit physical address used for instruction fetch. It holds a code segment register, the 32-bit instruction pointer, a small bank of general registers and four control registers. The segment register has two parts. The 16-bit selector is visible. The base is hidden and is the value that actually feeds the address adder. The fetch address is the hidden base plus the zero-extended pointer. The sum is taken modulo 2^32.

A synchronous reset sets a hidden base that the usual shift-by-four rule could never produce from the reset selector. Because of this, the first fetches after reset land just below the top of the 4 GB space. The first explicit load of the code segment in real mode rewrites the base from the selector and ends this aliasing. After that, addresses follow the real-mode rule: the selector times sixteen, plus the offset.

The surrounding sequencer has three ways to act on the block:
- move the pointer, by adding an instruction length or by loading a target;
- load the segment, for a far transfer;
- write the control registers.

It reads the general and control registers through combinational read ports.

Top module: `fetch_addr_gen`

## Requirements
- R1: In the first cycle after reset is released, `cs_sel` is F000h, `cs_base` is FFFF0000h, `ip` is 0000FFF0h and `fetch_addr` is FFFFFFF0h.
- R2: After reset, `gpr_rdata` reads `STEPPING_ID` (default 00000663h) at `gpr_idx` = 2 and zero at every other index. The index order is 0 accumulator, 1 count, 2 data, 3 base, 4 stack pointer, 5 frame pointer, 6 source index, 7 destination index.
- R3: After reset, `cr_rdata` reads 60000010h at `cr_idx` = 0 and zero at indices 1, 2 and 3. The index encoding is 0 = CR0, 1 = CR2, 2 = CR3, 3 = CR4. Bit 31 (paging) and bit 0 (protection enable) of CR0 are clear.
- R4: `fetch_addr` always equals `cs_base` plus `ip`, modulo 2^32. It follows register changes in the same cycle as the registers change.
- R5: When `seg_ld` is high and CR0 bit 0 is clear, the next cycle shows `cs_sel` equal to `seg_sel_in` and `cs_base` equal to `seg_sel_in` shifted left by 4 and zero-extended. Example: selector 2000h with pointer 1234h fetches 21234h.
- R6: When `seg_ld` is high and CR0 bit 0 is set, the load has no effect: `cs_sel` and `cs_base` keep their values.
- R7: When `ip_ld` is high, the next cycle shows `ip` equal to `ip_in`. This takes priority over `ip_inc`.
- R8: When `ip_inc` is high and `ip_ld` is low, `ip` advances by the zero-extended `ip_step` and wraps modulo 2^32.
- R9: When `cr_we` is high, the next cycle shows the control register selected by `cr_idx` holding `cr_wdata`. The other control registers keep their values.
- R10: Without a segment load, the hidden base keeps its value, even while the pointer moves. This includes the top-of-memory reset base.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| seg_ld | input | 1 | Load the code segment from `seg_sel_in` |
| seg_sel_in | input | 16 | New selector value |
| ip_ld | input | 1 | Load the pointer from `ip_in` |
| ip_in | input | 32 | Pointer load value |
| ip_inc | input | 1 | Advance the pointer by `ip_step` |
| ip_step | input | STEP_W | Instruction length to add |
| cr_we | input | 1 | Control register write strobe |
| cr_idx | input | 2 | Control register select, used for both read and write |
| cr_wdata | input | 32 | Control register write data |
| gpr_idx | input | 3 | General register read select |
| cr_rdata | output | 32 | Selected control register |
| gpr_rdata | output | 32 | Selected general register |
| cs_sel | output | 16 | Visible code segment selector |
| cs_base | output | 32 | Hidden code segment base |
| ip | output | 32 | Instruction pointer |
| fetch_addr | output | 32 | Physical fetch address |

## Verification
The assertions rely on the control inputs being held stable across each rising edge, and on reset being asserted before the first checked edge. They also rely on `cr_idx` being the write target whenever `cr_we` is high. The bench changes every input only on the falling edge and starts with reset held high for several cycles. It aims each control register write with `cr_idx` in the same cycle.

Segment loads with protection enabled are tried only after CR0 has been written through the normal port. The check for that case is therefore made against state the bench has established itself.

// File: rtl/fag_pkg.sv
package fag_pkg;
    localparam int ADDR_W    = 32;
    localparam int SEL_W     = 16;
    localparam int SEG_SHIFT = 4;
    localparam int N_GPR     = 8;
    localparam int N_CR      = 4;
    localparam int GPR_DATA  = 2;

    localparam logic [SEL_W-1:0]  RST_SEL  = 16'hF000;
    localparam logic [ADDR_W-1:0] RST_BASE = 32'hFFFF_0000;
    localparam logic [ADDR_W-1:0] RST_IP   = 32'h0000_FFF0;
    localparam logic [ADDR_W-1:0] RST_CR0  = 32'h6000_0010;

    typedef struct packed {
        logic [SEL_W-1:0]  sel;
        logic [ADDR_W-1:0] base;
    } cseg_t;
endpackage

// File: rtl/seg_unit.sv
module seg_unit
    import fag_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic              pe,
    input  logic [SEL_W-1:0]  sel_in,
    output logic [SEL_W-1:0]  sel,
    output logic [ADDR_W-1:0] base
);
    localparam int PAD_W = ADDR_W - SEL_W - SEG_SHIFT;

    cseg_t seg_d, seg_q;

    always_comb begin
        seg_d = seg_q;
        if (rst) begin
            seg_d.sel  = RST_SEL;
            seg_d.base = RST_BASE;
        end else if (load && !pe) begin
            seg_d.sel  = sel_in;
            seg_d.base = {{PAD_W{1'b0}}, sel_in, {SEG_SHIFT{1'b0}}};
        end
    end

    always_ff @(posedge clk) seg_q <= seg_d;

    assign sel  = seg_q.sel;
    assign base = seg_q.base;

    p_real_load_r5: assert property (@(posedge clk) disable iff (rst)
        (load && !pe) |=> (sel == $past(sel_in) && base[SEL_W+SEG_SHIFT-1:SEG_SHIFT] == $past(sel_in)));

    p_prot_ignore_r6: assert property (@(posedge clk) disable iff (rst)
        (load && pe) |=> ($stable(sel) && $stable(base)));

    p_base_hold_r10: assert property (@(posedge clk) disable iff (rst)
        !load |=> $stable(base));
endmodule

// File: rtl/ip_unit.sv
module ip_unit
    import fag_pkg::*;
#(
    parameter int STEP_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ld,
    input  logic [ADDR_W-1:0] ld_val,
    input  logic              inc,
    input  logic [STEP_W-1:0] step,
    output logic [ADDR_W-1:0] ip
);
    logic [ADDR_W-1:0] ip_d, ip_q;

    always_comb begin
        ip_d = ip_q;
        if (rst)      ip_d = RST_IP;
        else if (ld)  ip_d = ld_val;
        else if (inc) ip_d = ip_q + ADDR_W'(step);
    end

    always_ff @(posedge clk) ip_q <= ip_d;

    assign ip = ip_q;

    p_ip_load_r7: assert property (@(posedge clk) disable iff (rst)
        ld |=> ip == $past(ld_val));

    p_ip_step_r8: assert property (@(posedge clk) disable iff (rst)
        (inc && !ld) |=> (ip - $past(ip)) == ADDR_W'($past(step)));
endmodule

// File: rtl/ctrl_regs.sv
module ctrl_regs
    import fag_pkg::*;
#(
    parameter logic [ADDR_W-1:0] STEPPING_ID = 32'h0000_0663
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     cr_we,
    input  logic [$clog2(N_CR)-1:0]  cr_idx,
    input  logic [ADDR_W-1:0]        cr_wdata,
    input  logic [$clog2(N_GPR)-1:0] gpr_idx,
    output logic [ADDR_W-1:0]        cr_rdata,
    output logic [ADDR_W-1:0]        gpr_rdata,
    output logic                     pe
);
    typedef struct packed {
        logic [N_CR-1:0][ADDR_W-1:0]  cr;
        logic [N_GPR-1:0][ADDR_W-1:0] gpr;
    } ctrl_t;

    ctrl_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (rst) begin
            for (int i = 0; i < N_CR; i++)
                st_d.cr[i] = (i == 0) ? RST_CR0 : '0;
            for (int i = 0; i < N_GPR; i++)
                st_d.gpr[i] = (i == GPR_DATA) ? STEPPING_ID : '0;
        end else if (cr_we) begin
            st_d.cr[cr_idx] = cr_wdata;
        end
    end

    always_ff @(posedge clk) st_q <= st_d;

    assign cr_rdata  = st_q.cr[cr_idx];
    assign gpr_rdata = st_q.gpr[gpr_idx];
    assign pe        = st_q.cr[0][0];

    p_cr_write_r9: assert property (@(posedge clk) disable iff (rst)
        cr_we |=> st_q.cr[$past(cr_idx)] == $past(cr_wdata));

    p_gpr_hold_r2: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> $stable(st_q.gpr));
endmodule

// File: rtl/fetch_addr_gen.sv
module fetch_addr_gen
    import fag_pkg::*;
#(
    parameter int                STEP_W      = 4,
    parameter logic [31:0]       STEPPING_ID = 32'h0000_0663
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              seg_ld,
    input  logic [15:0]       seg_sel_in,
    input  logic              ip_ld,
    input  logic [31:0]       ip_in,
    input  logic              ip_inc,
    input  logic [STEP_W-1:0] ip_step,
    input  logic              cr_we,
    input  logic [1:0]        cr_idx,
    input  logic [31:0]       cr_wdata,
    input  logic [2:0]        gpr_idx,
    output logic [31:0]       cr_rdata,
    output logic [31:0]       gpr_rdata,
    output logic [15:0]       cs_sel,
    output logic [31:0]       cs_base,
    output logic [31:0]       ip,
    output logic [31:0]       fetch_addr
);
    logic pe;
    logic rst_seen_q;

    seg_unit u_seg (
        .clk(clk), .rst(rst), .load(seg_ld), .pe(pe),
        .sel_in(seg_sel_in), .sel(cs_sel), .base(cs_base)
    );

    ip_unit #(.STEP_W(STEP_W)) u_ip (
        .clk(clk), .rst(rst), .ld(ip_ld), .ld_val(ip_in),
        .inc(ip_inc), .step(ip_step), .ip(ip)
    );

    ctrl_regs #(.STEPPING_ID(STEPPING_ID)) u_ctrl (
        .clk(clk), .rst(rst), .cr_we(cr_we), .cr_idx(cr_idx),
        .cr_wdata(cr_wdata), .gpr_idx(gpr_idx), .cr_rdata(cr_rdata),
        .gpr_rdata(gpr_rdata), .pe(pe)
    );

    assign fetch_addr = cs_base + ip;

    always_ff @(posedge clk) rst_seen_q <= rst;

    p_reset_vector_r1: assert property (@(posedge clk) disable iff (rst)
        rst_seen_q |-> (fetch_addr == 32'hFFFF_FFF0 && cs_sel == 16'hF000));

    p_reset_pe_clear_r3: assert property (@(posedge clk) disable iff (rst)
        rst_seen_q |-> !pe);
endmodule

// File: tb/fetch_addr_gen_bench.sv
module fetch_addr_gen_bench;
    localparam int CLK_PERIOD = 10;
    localparam int STEP_W = 4;
    localparam logic [31:0] STEP_ID = 32'h0000_0663;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic seg_ld = 0, ip_ld = 0, ip_inc = 0, cr_we = 0;
    logic [15:0] seg_sel_in = '0;
    logic [31:0] ip_in = '0, cr_wdata = '0;
    logic [STEP_W-1:0] ip_step = '0;
    logic [1:0] cr_idx = '0;
    logic [2:0] gpr_idx = '0;
    logic [31:0] cr_rdata, gpr_rdata, cs_base, ip, fetch_addr;
    logic [15:0] cs_sel;

    int n_chk = 0;
    int n_fail = 0;
    logic [31:0] exp_ip;

    always #(CLK_PERIOD/2) clk = ~clk;

    fetch_addr_gen #(.STEP_W(STEP_W), .STEPPING_ID(STEP_ID)) u_fetch_addr_gen (
        .clk(clk), .rst(rst), .seg_ld(seg_ld), .seg_sel_in(seg_sel_in),
        .ip_ld(ip_ld), .ip_in(ip_in), .ip_inc(ip_inc), .ip_step(ip_step),
        .cr_we(cr_we), .cr_idx(cr_idx), .cr_wdata(cr_wdata), .gpr_idx(gpr_idx),
        .cr_rdata(cr_rdata), .gpr_rdata(gpr_rdata), .cs_sel(cs_sel),
        .cs_base(cs_base), .ip(ip), .fetch_addr(fetch_addr)
    );

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s got %h expected %h", req, got, exp);
        end
    endtask

    task automatic cyc();
        @(negedge clk);
        seg_ld = 0; ip_ld = 0; ip_inc = 0; cr_we = 0;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        // R1 reset vector
        chk("R1 sel", {16'h0, cs_sel}, 32'h0000_F000);
        chk("R1 base", cs_base, 32'hFFFF_0000);
        chk("R1 ip", ip, 32'h0000_FFF0);
        chk("R1 fetch", fetch_addr, 32'hFFFF_FFF0);
        // R2 general registers
        for (int i = 0; i < 8; i++) begin
            gpr_idx = 3'(i); #1;
            chk("R2 gpr", gpr_rdata, (i == 2) ? STEP_ID : 32'h0);
        end
        // R3 control registers
        for (int i = 0; i < 4; i++) begin
            cr_idx = 2'(i); #1;
            chk("R3 cr", cr_rdata, (i == 0) ? 32'h6000_0010 : 32'h0);
        end
        // R10 aliasing persists while pointer moves
        ip_inc = 1; ip_step = 4'd2; cyc();
        ip_inc = 1; ip_step = 4'd2; cyc();
        ip_inc = 1; ip_step = 4'd2; cyc();
        chk("R10 base", cs_base, 32'hFFFF_0000);
        chk("R4 fetch", fetch_addr, 32'hFFFF_FFF6);
        // R7 load beats increment
        ip_ld = 1; ip_in = 32'h0; ip_inc = 1; ip_step = 4'd7; cyc();
        chk("R7 ip", ip, 32'h0);
        chk("R4 fetch", fetch_addr, 32'hFFFF_0000);
        // R8 wrap
        ip_ld = 1; ip_in = 32'hFFFF_FFFE; cyc();
        ip_inc = 1; ip_step = 4'd5; cyc();
        chk("R8 wrap", ip, 32'h0000_0003);
        chk("R4 fetch wrap", fetch_addr, 32'hFFFF_0003);
        // R5 worked example
        seg_ld = 1; seg_sel_in = 16'h2000; ip_ld = 1; ip_in = 32'h1234; cyc();
        chk("R5 sel", {16'h0, cs_sel}, 32'h2000);
        chk("R5 fetch", fetch_addr, 32'h0002_1234);
        // R5/R4 sweep of selectors with pointer loads
        for (int s = 0; s < 256; s++) begin
            seg_ld = 1; seg_sel_in = 16'(s * 257);
            ip_ld = 1; ip_in = 32'((s * 32'h0101_0101) ^ 32'h0000_5A5A);
            cyc();
            chk("R5 sel", {16'h0, cs_sel}, 32'(s * 257));
            chk("R5 base", cs_base, 32'(s * 257) << 4);
            chk("R4 fetch", fetch_addr, (32'(s * 257) << 4) + 32'((s * 32'h0101_0101) ^ 32'h0000_5A5A));
        end
        // R8 sweep every step length
        ip_ld = 1; ip_in = 32'h0000_1000; cyc();
        exp_ip = 32'h0000_1000;
        for (int k = 0; k < 16; k++) begin
            ip_inc = 1; ip_step = 4'(k); cyc();
            exp_ip = exp_ip + 32'(k);
            chk("R8 step", ip, exp_ip);
            chk("R4 fetch", fetch_addr, 32'hFFFF0 + exp_ip);
        end
        // R10 base held across pointer activity
        chk("R10 base", cs_base, 32'h000F_FFF0);
        // R9 control register writes
        for (int i = 1; i < 4; i++) begin
            cr_we = 1; cr_idx = 2'(i); cr_wdata = 32'hC0DE_0000 + 32'(i); cyc();
        end
        for (int i = 1; i < 4; i++) begin
            cr_idx = 2'(i); #1;
            chk("R9 cr", cr_rdata, 32'hC0DE_0000 + 32'(i));
        end
        cr_idx = 2'd0; #1;
        chk("R9 cr0 untouched", cr_rdata, 32'h6000_0010);
        // R6 segment load ignored with protection enabled
        cr_we = 1; cr_idx = 2'd0; cr_wdata = 32'h6000_0011; cyc();
        chk("R9 cr0", cr_rdata, 32'h6000_0011);
        seg_ld = 1; seg_sel_in = 16'h1234; cyc();
        chk("R6 sel", {16'h0, cs_sel}, 32'h0000_FFFF);
        chk("R6 base", cs_base, 32'h000F_FFF0);
        // back to real mode, load works again
        cr_we = 1; cr_idx = 2'd0; cr_wdata = 32'h6000_0010; cyc();
        seg_ld = 1; seg_sel_in = 16'h1234; cyc();
        chk("R5 sel", {16'h0, cs_sel}, 32'h0000_1234);
        chk("R5 base", cs_base, 32'h0001_2340);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule